// File: doc/BRIEF.md
# ROM Bank Select and Transfer Acknowledge Timer

This block sits between a processor with a 24-bit address bus and four 128K x 8 read-only memory devices. Together the four devices hold a 512K x 8 window that starts at 0xD80000 and ends at 0xDFFFFF. The block compares the upper address bits with the window's fixed tag. It uses the next two bits to pick one device, and it drives that device's active-low chip enable. A shared active-low output enable opens the selected device's data drivers on read cycles.

The devices are slower than the bus clock. For every access inside the window, the block counts a fixed number of wait states before it drives the active-low transfer acknowledge back to the processor. The number of wait states comes from the device access time and the clock period, rounded up. The defaults are 58 ns and 5 ns, which give 12 wait states. The acknowledge stays low until the processor releases the address strobe.

All outputs are registered. They reflect the bus inputs sampled at the preceding rising clock edge.

Top module: `rom_bank_select`

## Requirements
- R1: An access hits the window when `as_n` is low and `addr[23:19]` equals 5'b11011, which is the range 0xD80000 to 0xDFFFFF. Any other address is a miss.
- R2: One clock edge after a hit is sampled, exactly one `ce_n` bit is low. Its index is `addr[18:17]`, so bank 0 starts at 0xD80000, bank 1 at 0xDA0000, bank 2 at 0xDC0000 and bank 3 at 0xDE0000. The selection follows address changes within the window on every edge.
- R3: After an edge that samples a miss, or that samples `as_n` high, all `ce_n` bits, `oe_n` and `dtack_n` are high.
- R4: `oe_n` is low after an edge only when that edge sampled a hit with `rd_n` low. A hit with `rd_n` high enables the device but leaves `oe_n` high.
- R5: The wait-state count is ceil(ACCESS_NS / CLK_NS), which is 12 by default. `dtack_n` goes low on the edge that samples the 13th consecutive hit, and not before.
- R6: `dtack_n` stays low while hits continue to be sampled. It returns high on the first edge that samples a miss or a released strobe. The wait count then starts again from zero for the next access.
- R7: A synchronous active-high `rst` drives every `ce_n` bit, `oe_n` and `dtack_n` high and clears the wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 24 | Processor address bus |
| as_n | input | 1 | Address strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| ce_n | output | 4 | Per-device chip enables, active low |
| oe_n | output | 1 | Shared output enable, active low |
| dtack_n | output | 1 | Transfer acknowledge, active low |

## Verification
The chip enables and the output enable are due one edge after the inputs that cause them. The acknowledge is due on the edge that samples the thirteenth consecutive hit, and it clears one edge after the strobe is released. The bench changes inputs a little after each rising edge. A behavioural model that counts consecutive hits computes the expected outputs at each rising edge, and the design is compared with it at the following falling edge. The stimuli include hits in every bank, the two boundaries of the window, accesses aborted before the acknowledge, an address that leaves the window mid-access, and a reset applied during an access.

// File: rtl/rom_bank_select.sv
module rom_bank_select #(
  parameter int ADDR_W = 24,
  parameter int DEV_AW = 17,
  parameter int DEVICES = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'hD80000,
  parameter int ACCESS_NS = 58,
  parameter int CLK_NS = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               as_n,
  input  logic               rd_n,
  output logic [DEVICES-1:0] ce_n,
  output logic               oe_n,
  output logic               dtack_n
);
  localparam int SEL_W = $clog2(DEVICES);
  localparam int TAG_LSB = DEV_AW + SEL_W;
  localparam int TAG_W = ADDR_W - TAG_LSB;
  localparam int WAIT_STATES = (ACCESS_NS + CLK_NS - 1) / CLK_NS;
  localparam int CNT_W = $clog2(WAIT_STATES + 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_STATES);
  localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:TAG_LSB];

  logic             hit;
  logic [SEL_W-1:0] bank;
  logic [DEVICES-1:0] dec;
  logic [CNT_W-1:0] waited;

  assign hit  = !as_n && (addr[ADDR_W-1:TAG_LSB] == BASE_TAG);
  assign bank = addr[TAG_LSB-1:DEV_AW];

  for (genvar i = 0; i < DEVICES; i++) begin : g_dec
    assign dec[i] = hit && (bank == SEL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_n    <= '1;
      oe_n    <= 1'b1;
      dtack_n <= 1'b1;
      waited  <= '0;
    end else begin
      ce_n <= ~dec;
      oe_n <= !(hit && !rd_n);
      if (!hit) begin
        waited  <= '0;
        dtack_n <= 1'b1;
      end else if (waited != WAIT_LAST) begin
        waited  <= waited + 1'b1;
        dtack_n <= 1'b1;
      end else begin
        dtack_n <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rom_bank_select_chk.sv
module rom_bank_select_chk #(
  parameter int ADDR_W = 24,
  parameter int DEV_AW = 17,
  parameter int DEVICES = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'hD80000,
  parameter int ACCESS_NS = 58,
  parameter int CLK_NS = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  addr,
  input logic               as_n,
  input logic               rd_n,
  input logic [DEVICES-1:0] ce_n,
  input logic               oe_n,
  input logic               dtack_n
);
  localparam int SEL_W = $clog2(DEVICES);
  localparam int NEED = (ACCESS_NS + CLK_NS - 1) / CLK_NS + 1;
  localparam logic [ADDR_W:0] LIMIT = {1'b0, BASE_ADDR} + ((ADDR_W+1)'(DEVICES) << DEV_AW);

  logic in_win;
  logic [SEL_W-1:0] want_bank;
  int   run;
  logic seen, rst_q;

  assign in_win = !as_n && ({1'b0, addr} >= {1'b0, BASE_ADDR}) && ({1'b0, addr} < LIMIT);
  assign want_bank = SEL_W'((addr - BASE_ADDR) >> DEV_AW);

  always_ff @(posedge clk) begin
    seen  <= 1'b1;
    rst_q <= rst;
    if (rst || !in_win) run <= 0;
    else if (run < NEED) run <= run + 1;
  end

  assert_one_device_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(~ce_n) <= 1);
  assert_bank_pick_R2: assert property (@(posedge clk) disable iff (rst)
    in_win |=> (ce_n[$past(want_bank)] == 1'b0));
  assert_miss_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !in_win |=> (&ce_n && oe_n && dtack_n));
  assert_oe_with_ce_R4: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !(&ce_n));
  assert_no_early_ack_R5: assert property (@(posedge clk) disable iff (rst)
    seen && !dtack_n |-> run >= NEED);
  assert_ack_held_R6: assert property (@(posedge clk) disable iff (rst)
    seen && run >= NEED |-> !dtack_n);
  assert_reset_idle_R7: assert property (@(posedge clk)
    seen && rst_q |-> (&ce_n && oe_n && dtack_n));
endmodule

bind rom_bank_select rom_bank_select_chk #(
  .ADDR_W(ADDR_W), .DEV_AW(DEV_AW), .DEVICES(DEVICES),
  .BASE_ADDR(BASE_ADDR), .ACCESS_NS(ACCESS_NS), .CLK_NS(CLK_NS)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .as_n(as_n), .rd_n(rd_n),
  .ce_n(ce_n), .oe_n(oe_n), .dtack_n(dtack_n)
);

// File: tb/test_rom_bank_select.sv
module test_rom_bank_select;
  localparam int WAITS = (58 + 5 - 1) / 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] addr = 24'h0;
  logic        as_n = 1'b1;
  logic        rd_n = 1'b1;
  logic [3:0]  ce_n;
  logic        oe_n, dtack_n;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  rom_bank_select i_rom_bank_select (
    .clk(clk), .rst(rst), .addr(addr), .as_n(as_n), .rd_n(rd_n),
    .ce_n(ce_n), .oe_n(oe_n), .dtack_n(dtack_n)
  );

  logic [3:0] m_ce = 4'hF;
  logic m_oe = 1'b1, m_dt = 1'b1, m_hit = 1'b0, m_rst = 1'b0, started = 1'b0;
  int run = 0;

  always @(posedge clk) begin
    bit h;
    started <= 1'b1;
    h = !as_n && addr >= 24'hD80000 && addr <= 24'hDFFFFF;
    m_rst <= rst;
    m_hit <= h;
    if (rst) begin
      run = 0;
      m_ce <= 4'hF; m_oe <= 1'b1; m_dt <= 1'b1;
    end else begin
      run = h ? run + 1 : 0;
      m_ce <= h ? ~(4'b1 << ((addr - 24'hD80000) / 24'h20000)) : 4'hF;
      m_oe <= !(h && !rd_n);
      m_dt <= !(run > WAITS);
    end
  end

  task automatic check(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      if (m_rst) begin
        check("R7", "ce_n", ce_n, m_ce);
        check("R7", "oe_n", {3'b0, oe_n}, {3'b0, m_oe});
        check("R7", "dtack_n", {3'b0, dtack_n}, {3'b0, m_dt});
      end else if (!m_hit) begin
        check("R3", "ce_n", ce_n, m_ce);
        check("R3", "oe_n", {3'b0, oe_n}, {3'b0, m_oe});
        check("R6", "dtack_n", {3'b0, dtack_n}, {3'b0, m_dt});
      end else begin
        check("R1 R2", "ce_n", ce_n, m_ce);
        check("R4", "oe_n", {3'b0, oe_n}, {3'b0, m_oe});
        check(m_dt ? "R5" : "R5 R6", "dtack_n", {3'b0, dtack_n}, {3'b0, m_dt});
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic access(input logic [23:0] a, input logic rd, input int hold);
    addr = a; rd_n = rd; as_n = 1'b0;
    step(hold);
    as_n = 1'b1; rd_n = 1'b1;
    step(2);
  endtask

  task automatic report;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R2 R5 R6: full reads in each bank
    access(24'hD80000, 1'b0, WAITS + 4);
    access(24'hDA1234, 1'b0, WAITS + 4);
    access(24'hDC0000, 1'b0, WAITS + 4);
    access(24'hDFFFFF, 1'b0, WAITS + 4);
    // R1 R3: just outside the window
    access(24'hD7FFFF, 1'b0, WAITS + 4);
    access(24'hE00000, 1'b0, WAITS + 4);
    access(24'h580000, 1'b0, 6);
    // R4: hit with read strobe high
    access(24'hDE0010, 1'b1, WAITS + 3);
    // R5: abort exactly before and at the acknowledge
    access(24'hDA0000, 1'b0, WAITS);
    access(24'hDA0000, 1'b0, WAITS + 1);
    // R2: bank switch inside one strobe; R6: leaving the window clears
    addr = 24'hD80004; rd_n = 1'b0; as_n = 1'b0;
    step(5);
    addr = 24'hDC0004; step(3);
    addr = 24'hD00000; step(2);
    addr = 24'hDE0000; step(WAITS + 3);
    rd_n = 1'b1; step(2);
    as_n = 1'b1; step(2);
    // R7: reset during an access
    addr = 24'hDA0000; rd_n = 1'b0; as_n = 1'b0;
    step(WAITS + 2);
    rst = 1'b1; step(2);
    rst = 1'b0; step(WAITS + 3);
    as_n = 1'b1; step(3);
    report();
  end
endmodule